// File: doc/BRIEF.md
# Peripheral Configuration Access Engine

This block sits on the host side of a two-target peripheral link. It runs one configuration transaction at a time toward a selected target. Software first loads a 32-bit data register, then writes a control word. The control word carries a start/busy flag, a status field, the target number, the transaction kind and a 12-bit register address. The engine checks the request against the target-enable strap, the alignment rule and the write-lock policy. A request that fails the check finishes at once with an error code. A request that passes is presented on a valid/ready request port. The engine then waits for a single response beat, or gives up after a fixed number of cycles.

There are four transaction kinds: configuration read, configuration write, status read and in-band reset. They share the one control word. A configuration read returns all 32 bits of response data. A status read keeps only the low half. Status reads and in-band resets always go out with address zero. When the lock input is asserted, configuration writes into the lower half of the address space are refused. The exception is a target whose recovery flag is raised.

Top module: `pcfg_engine`

## Requirements
- R1: After reset, the control readback, the data readback and `req_valid` are all zero.
- R2: Writing the control word with bit 31 set while idle launches a transaction. Bit 31 reads 1 until the transaction completes, then the hardware clears it to 0.
- R3: The status field sits at bits 30:28 and reads 000 for success. Each 1 written to these bits clears the matching status bit. This clearing also works while a transaction is busy.
- R4: The target number sits at bits 20:19. A value of 2 or 3, or a value of 1 while `strap_second_en` is 0, completes with status 001 and no request handshake. This check has the highest priority.
- R5: The address sits at bits 11:0. A configuration read or write whose address has bits 1:0 not equal to 00 completes with status 010 and no handshake.
- R6: The kind sits at bits 17:16: 00 configuration read, 01 configuration write, 10 status read, 11 in-band reset. A successful configuration read loads all 32 response bits into the data register.
- R7: Status reads and in-band resets are issued with address 0 and skip the alignment check. A successful status read loads {16'h0000, response[15:0]}. An in-band reset leaves the data register unchanged.
- R8: When `lock_low` is 1, a configuration write to an address at or below 0x7FF completes with status 011 and no handshake, unless `recov_flag` for that target (bit 0 for target 0, bit 1 for target 1) is 1. Addresses from 0x800 up are never locked.
- R9: A configuration write sends the data register contents on `req_wdata`. While busy, writes to the data register and to the control word's target, kind and address fields are ignored.
- R10: `req_valid` stays high, with the request fields steady, until a cycle in which `req_ready` is high. Exactly one handshake takes place per accepted request.
- R11: If no response arrives within TIMEOUT_CYC (1024) cycles of issue, the transaction completes with status 100 and `req_valid` drops.
- R12: The 3-bit response status is copied into the status field. The data register is updated only when that response status is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_second_en | input | 1 | Enables target 1 |
| lock_low | input | 1 | Locks configuration writes to addresses 0..0x7FF |
| recov_flag | input | 2 | Per-target recovery flag that overrides the lock |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the control word, 1 selects the data register |
| reg_wdata | input | 32 | Register write data |
| ctl_rdata | output | 32 | Control word readback |
| dat_rdata | output | 32 | Data register readback |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_id | output | 2 | Request target number |
| req_type | output | 2 | Request kind |
| req_addr | output | 12 | Request register address |
| req_wdata | output | 32 | Request write data |
| rsp_valid | input | 1 | Response beat valid |
| rsp_status | input | 3 | Response status |
| rsp_data | input | 32 | Response data |

## Verification
The assertions on the request port assume three things about the inputs. First, `strap_second_en`, `lock_low` and `recov_flag` do not change while a transaction is in flight. Second, `rsp_valid` comes only after a handshake. Third, `req_ready` is not raised in the same cycle the timeout expires. The bench therefore changes the strap, lock and recovery inputs only while the engine is idle. Its responder model raises `req_ready` only against a pending `req_valid` and then returns one response beat after a programmable latency. In timeout scenarios it stays silent for the whole window.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int TID_W  = 2;
    localparam int STAT_W = 3;

    typedef enum logic [1:0] {
        XF_CFG_RD = 2'b00,
        XF_CFG_WR = 2'b01,
        XF_STS_RD = 2'b10,
        XF_RESET  = 2'b11
    } xfer_t;

    localparam logic [STAT_W-1:0] ST_OK       = 3'b000;
    localparam logic [STAT_W-1:0] ST_BAD_ID   = 3'b001;
    localparam logic [STAT_W-1:0] ST_MISALIGN = 3'b010;
    localparam logic [STAT_W-1:0] ST_LOCKED   = 3'b011;
    localparam logic [STAT_W-1:0] ST_TIMEOUT  = 3'b100;

    typedef struct packed {
        logic [TID_W-1:0]  tid;
        xfer_t             xfer;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    // Kinds that carry a real register address
    function automatic logic uses_addr(xfer_t x);
        return (x == XF_CFG_RD) || (x == XF_CFG_WR);
    endfunction

    function automatic cmd_t decode_ctl(logic [DATA_W-1:0] w);
        cmd_t c;
        c.tid  = w[20:19];
        c.xfer = xfer_t'(w[17:16]);
        c.addr = w[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] encode_ctl(logic busy, logic [STAT_W-1:0] st, cmd_t c);
        return {busy, st, 7'b0, c.tid, 1'b0, c.xfer, 4'b0, c.addr};
    endfunction

endpackage

// File: rtl/pcfg_check.sv
module pcfg_check
    import pcfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LOCK_TOP = 12'h7FF,
    parameter int                NUM_TGT  = 2
) (
    input  cmd_t               cmd,
    input  logic               strap_second_en,
    input  logic               lock_low,
    input  logic [NUM_TGT-1:0] recov_flag,
    output logic               reject,
    output logic [STAT_W-1:0]  reject_code
);

    logic [NUM_TGT-1:0] tgt_present;
    logic               id_bad;
    logic               misaligned;
    logic               write_locked;

    generate
        for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
            if (g == 0) begin : g_first
                assign tgt_present[g] = 1'b1;
            end else begin : g_extra
                assign tgt_present[g] = strap_second_en;
            end
        end
    endgenerate

    always_comb begin
        id_bad = 1'b1;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (int'(cmd.tid) == i && tgt_present[i]) id_bad = 1'b0;
        end
    end

    assign misaligned = uses_addr(cmd.xfer) && (cmd.addr[1:0] != 2'b00);

    always_comb begin
        write_locked = 1'b0;
        if (cmd.xfer == XF_CFG_WR && cmd.addr <= LOCK_TOP && lock_low) begin
            write_locked = 1'b1;
            for (int i = 0; i < NUM_TGT; i++) begin
                if (int'(cmd.tid) == i && recov_flag[i]) write_locked = 1'b0;
            end
        end
    end

    // Priority: target number, then alignment, then lock
    always_comb begin
        reject      = 1'b1;
        reject_code = ST_OK;
        if (id_bad)            reject_code = ST_BAD_ID;
        else if (misaligned)   reject_code = ST_MISALIGN;
        else if (write_locked) reject_code = ST_LOCKED;
        else                   reject      = 1'b0;
    end

endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
    import pcfg_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              reject,
    input  logic [STAT_W-1:0] reject_code,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [STAT_W-1:0] rsp_status,
    output logic              req_valid,
    output logic              done,
    output logic [STAT_W-1:0] done_code,
    output logic              done_rsp
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_ISSUE, S_WAIT} seq_st_t;

    seq_st_t          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             in_flight;
    logic             tmo_hit;

    assign in_flight = (state_q == S_ISSUE) || (state_q == S_WAIT);
    assign tmo_hit   = in_flight && (cnt_q == CNT_LAST);
    assign req_valid = (state_q == S_ISSUE);

    always_comb begin
        state_d   = state_q;
        done      = 1'b0;
        done_code = ST_OK;
        done_rsp  = 1'b0;
        case (state_q)
            S_IDLE:  if (start) state_d = S_CHECK;
            S_CHECK: begin
                if (reject) begin
                    done      = 1'b1;
                    done_code = reject_code;
                    state_d   = S_IDLE;
                end else begin
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (tmo_hit) begin
                    done      = 1'b1;
                    done_code = ST_TIMEOUT;
                    state_d   = S_IDLE;
                end else if (req_ready) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (rsp_valid) begin
                    done      = 1'b1;
                    done_code = rsp_status;
                    done_rsp  = 1'b1;
                    state_d   = S_IDLE;
                end else if (tmo_hit) begin
                    done      = 1'b1;
                    done_code = ST_TIMEOUT;
                    state_d   = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_CHECK) cnt_q <= '0;
            else if (in_flight && !tmo_hit) cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !tmo_hit) |=> req_valid); // R10
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        in_flight |-> (cnt_q < CNT_W'(TIMEOUT_CYC))); // R11
    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (tmo_hit && !(state_q == S_WAIT && rsp_valid)) |=> !req_valid && state_q == S_IDLE); // R11
    AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

endmodule

// File: rtl/pcfg_engine.sv
module pcfg_engine
    import pcfg_pkg::*;
#(
    parameter int                TIMEOUT_CYC = 1024,
    parameter logic [ADDR_W-1:0] LOCK_TOP    = 12'h7FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_second_en,
    input  logic              lock_low,
    input  logic [1:0]        recov_flag,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctl_rdata,
    output logic [31:0]       dat_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_id,
    output logic [1:0]        req_type,
    output logic [11:0]       req_addr,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [2:0]        rsp_status,
    input  logic [31:0]       rsp_data
);

    localparam int HALF_W = DATA_W / 2;

    cmd_t              cmd_q;
    logic              busy_q;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] data_q;

    logic              ctl_wr, dat_wr, launch;
    logic              reject;
    logic [STAT_W-1:0] reject_code;
    logic              seq_done, seq_rsp;
    logic [STAT_W-1:0] seq_code;
    logic [DATA_W-1:0] rd_load;
    logic              unused_bits;

    assign ctl_wr = reg_wr_en && !reg_wr_sel;
    assign dat_wr = reg_wr_en &&  reg_wr_sel;
    assign launch = ctl_wr && !busy_q && reg_wdata[31];
    assign unused_bits = ^{reg_wdata[27:21], reg_wdata[18], reg_wdata[15:12]};

    pcfg_check #(
        .LOCK_TOP (LOCK_TOP),
        .NUM_TGT  (2)
    ) u_check (
        .cmd             (cmd_q),
        .strap_second_en (strap_second_en),
        .lock_low        (lock_low),
        .recov_flag      (recov_flag),
        .reject          (reject),
        .reject_code     (reject_code)
    );

    pcfg_seq #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (launch),
        .reject      (reject),
        .reject_code (reject_code),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_status  (rsp_status),
        .req_valid   (req_valid),
        .done        (seq_done),
        .done_code   (seq_code),
        .done_rsp    (seq_rsp)
    );

    // Data loaded on a clean response, by kind
    always_comb begin
        rd_load = data_q;
        if (seq_rsp && seq_code == ST_OK) begin
            case (cmd_q.xfer)
                XF_CFG_RD: rd_load = rsp_data;
                XF_STS_RD: rd_load = {{HALF_W{1'b0}}, rsp_data[HALF_W-1:0]};
                default:   rd_load = data_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            busy_q <= 1'b0;
            stat_q <= ST_OK;
            data_q <= '0;
        end else begin
            if (ctl_wr)           stat_q <= stat_q & ~reg_wdata[30:28];
            if (ctl_wr && !busy_q) cmd_q <= decode_ctl(reg_wdata);
            if (launch)           busy_q <= 1'b1;
            if (dat_wr && !busy_q) data_q <= reg_wdata;
            if (seq_done) begin
                busy_q <= 1'b0;
                stat_q <= seq_code;
                data_q <= rd_load;
            end
        end
    end

    assign ctl_rdata = encode_ctl(busy_q, stat_q, cmd_q);
    assign dat_rdata = data_q;
    assign req_id    = cmd_q.tid;
    assign req_type  = cmd_q.xfer;
    assign req_addr  = uses_addr(cmd_q.xfer) ? cmd_q.addr : '0;
    assign req_wdata = data_q;

    AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy_q); // R2
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(req_addr) && $stable(req_wdata) && $stable(req_id)); // R10
    AST_ID_LEGAL: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_id == 2'd0 || (req_id == 2'd1 && strap_second_en))); // R4
    AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_type[1]) |-> req_addr[1:0] == 2'b00); // R5
    AST_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type[1]) |-> req_addr == '0); // R7
    AST_LOCK_POLICY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type == 2'b01 && req_addr <= LOCK_TOP) |-> (!lock_low || recov_flag[req_id[0]])); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !seq_done) |=> $stable(data_q)); // R9

endmodule

// File: tb/tb_pcfg_engine.sv
module tb_pcfg_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_second_en = 1'b0;
    logic        lock_low = 1'b0;
    logic [1:0]  recov_flag = 2'b00;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctl_rdata, dat_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [1:0]  req_id, req_type;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_status = '0;
    logic [31:0] rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Responder controls and captures
    bit          rsp_on = 1;
    int          rdy_dly = 0;
    int          rsp_lat = 2;
    logic [2:0]  rsp_st = 3'b000;
    logic [31:0] rsp_dt = '0;
    int          hs_cnt = 0;
    int          hold_bad = 0;
    logic [1:0]  cap_id, cap_type;
    logic [11:0] cap_addr;
    logic [31:0] cap_wdata;

    always #2 clk = ~clk;

    pcfg_engine dut (
        .clk(clk), .rst(rst), .strap_second_en(strap_second_en), .lock_low(lock_low),
        .recov_flag(recov_flag), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .ctl_rdata(ctl_rdata), .dat_rdata(dat_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] mk(logic s, logic [2:0] st, logic [1:0] id, logic [1:0] ty, logic [11:0] a);
        return {s, st, 7'b0, id, 1'b0, ty, 4'b0, a};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr(logic sel, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle(int limit);
        int n = 0;
        while (ctl_rdata[31] && n < limit) begin
            @(negedge clk);
            n++;
        end
        check("R2 busy clears", {31'b0, ctl_rdata[31]}, 32'h0);
    endtask

    // Responder model
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_on && req_valid) begin
                logic [11:0] a0;
                a0 = req_addr;
                for (int k = 0; k < rdy_dly; k++) begin
                    @(negedge clk);
                    if (!req_valid || req_addr !== a0) hold_bad++;
                end
                req_ready = 1'b1;
                cap_id = req_id; cap_type = req_type; cap_addr = req_addr; cap_wdata = req_wdata;
                hs_cnt++;
                @(negedge clk);
                req_ready = 1'b0;
                for (int k = 0; k < rsp_lat; k++) @(negedge clk);
                rsp_valid = 1'b1; rsp_status = rsp_st; rsp_data = rsp_dt;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // Runs one transaction; returns handshake delta via check
    task automatic run(logic [1:0] id, logic [1:0] ty, logic [11:0] a, int exp_hs, string tag);
        int h0 = hs_cnt;
        wr(1'b0, mk(1'b1, 3'b000, id, ty, a));
        wait_idle(400);
        check(tag, hs_cnt - h0, exp_hs);
    endtask

    task automatic t_reset();
        check("R1 ctl after reset", ctl_rdata, 32'h0);
        check("R1 data after reset", dat_rdata, 32'h0);
        check("R1 req_valid after reset", {31'b0, req_valid}, 32'h0);
    endtask

    task automatic t_cfg_read();
        rsp_st = 3'b000; rsp_dt = 32'hCAFEF00D;
        wr(1'b0, mk(1'b1, 3'b000, 2'd0, 2'b00, 12'h010));
        check("R2 busy set on launch", {31'b0, ctl_rdata[31]}, 32'h1);
        wait_idle(400);
        check("R6 kind on port", {30'b0, cap_type}, 32'h0);
        check("R6 addr on port", {20'b0, cap_addr}, 32'h010);
        check("R6 full read data", dat_rdata, 32'hCAFEF00D);
        check("R3 ok status and idle", ctl_rdata, mk(1'b0, 3'b000, 2'd0, 2'b00, 12'h010));
    endtask

    task automatic t_status_and_reset();
        rsp_dt = 32'hABCD1234;
        run(2'd0, 2'b10, 12'h013, 1, "R7 status read misaligned addr accepted");
        check("R7 status read addr zero", {20'b0, cap_addr}, 32'h0);
        check("R7 status read low half", dat_rdata, 32'h0000_1234);
        rsp_dt = 32'hFFFF_FFFF;
        run(2'd0, 2'b11, 12'h040, 1, "R7 in-band reset handshake");
        check("R7 reset addr zero", {20'b0, cap_addr}, 32'h0);
        check("R7 reset kind", {30'b0, cap_type}, 32'h3);
        check("R7 reset keeps data", dat_rdata, 32'h0000_1234);
    endtask

    task automatic t_lock();
        lock_low = 1'b1; recov_flag = 2'b00;
        wr(1'b1, 32'h1234_5678);
        run(2'd0, 2'b01, 12'h800, 1, "R8 write above lock range");
        check("R9 write data on port", cap_wdata, 32'h1234_5678);
        check("R8 unlocked status", {29'b0, ctl_rdata[30:28]}, 32'h0);
        run(2'd0, 2'b01, 12'h7FC, 0, "R8 locked write no handshake");
        check("R8 locked status", {29'b0, ctl_rdata[30:28]}, 32'h3);
        recov_flag = 2'b10;
        run(2'd0, 2'b01, 12'h100, 0, "R8 other target flag no effect");
        check("R8 still locked", {29'b0, ctl_rdata[30:28]}, 32'h3);
        recov_flag = 2'b01;
        run(2'd0, 2'b01, 12'h100, 1, "R8 recovery flag allows write");
        check("R8 recovered status", {29'b0, ctl_rdata[30:28]}, 32'h0);
        lock_low = 1'b0; recov_flag = 2'b00;
        run(2'd0, 2'b01, 12'h100, 1, "R8 no lock allows write");
    endtask

    task automatic t_ids();
        strap_second_en = 1'b0;
        run(2'd1, 2'b00, 12'h010, 0, "R4 target1 without strap");
        check("R4 bad id status", {29'b0, ctl_rdata[30:28]}, 32'h1);
        strap_second_en = 1'b1;
        run(2'd2, 2'b00, 12'h010, 0, "R4 target2");
        check("R4 target2 status", {29'b0, ctl_rdata[30:28]}, 32'h1);
        run(2'd3, 2'b00, 12'h001, 0, "R4 target3 misaligned");
        check("R4 id beats alignment", {29'b0, ctl_rdata[30:28]}, 32'h1);
        run(2'd1, 2'b00, 12'h020, 1, "R4 target1 with strap");
        check("R4 target1 id on port", {30'b0, cap_id}, 32'h1);
        strap_second_en = 1'b0;
    endtask

    task automatic t_misalign();
        run(2'd0, 2'b00, 12'h012, 0, "R5 misaligned read");
        check("R5 read status", {29'b0, ctl_rdata[30:28]}, 32'h2);
        run(2'd0, 2'b01, 12'h901, 0, "R5 misaligned write");
        check("R5 write status", {29'b0, ctl_rdata[30:28]}, 32'h2);
    endtask

    task automatic t_clear();
        wr(1'b0, mk(1'b0, 3'b001, 2'd0, 2'b00, 12'h000));
        check("R3 partial clear", {29'b0, ctl_rdata[30:28]}, 32'h2);
        wr(1'b0, mk(1'b0, 3'b111, 2'd0, 2'b00, 12'h000));
        check("R3 full clear", ctl_rdata, 32'h0);
    endtask

    task automatic t_busy_ignore();
        lock_low = 1'b1;
        run(2'd0, 2'b01, 12'h010, 0, "R8 set lock error");
        lock_low = 1'b0;
        rsp_lat = 30; rsp_st = 3'b000;
        wr(1'b1, 32'hAAAA_0000);
        wr(1'b0, mk(1'b1, 3'b000, 2'd0, 2'b01, 12'h900));
        check("R3 old status kept while busy", {29'b0, ctl_rdata[30:28]}, 32'h3);
        wr(1'b1, 32'h5555_5555);
        wr(1'b0, mk(1'b0, 3'b000, 2'd1, 2'b10, 12'h444));
        check("R9 fields ignored while busy", ctl_rdata, mk(1'b1, 3'b011, 2'd0, 2'b01, 12'h900));
        wr(1'b0, mk(1'b0, 3'b111, 2'd1, 2'b10, 12'h444));
        check("R3 clear while busy", ctl_rdata, mk(1'b1, 3'b000, 2'd0, 2'b01, 12'h900));
        wait_idle(400);
        check("R9 write data kept", cap_wdata, 32'hAAAA_0000);
        check("R9 data reg unchanged", dat_rdata, 32'hAAAA_0000);
        rsp_lat = 2;
    endtask

    task automatic t_rsp_error();
        rsp_st = 3'b101; rsp_dt = 32'h0BAD_BEEF;
        run(2'd0, 2'b00, 12'h020, 1, "R12 error response handshake");
        check("R12 status copied", {29'b0, ctl_rdata[30:28]}, 32'h5);
        check("R12 data not loaded", dat_rdata, 32'hAAAA_0000);
        rsp_st = 3'b000;
    endtask

    task automatic t_hold();
        rdy_dly = 5; rsp_dt = 32'h0000_00F0;
        hold_bad = 0;
        run(2'd0, 2'b00, 12'h0F0, 1, "R10 one handshake");
        check("R10 valid and addr held", hold_bad, 0);
        check("R10 data after delayed ready", dat_rdata, 32'h0000_00F0);
        rdy_dly = 0;
    endtask

    task automatic t_timeout();
        int h0 = hs_cnt;
        rsp_on = 0;
        wr(1'b0, mk(1'b1, 3'b000, 2'd0, 2'b00, 12'h030));
        repeat (1000) @(negedge clk);
        check("R11 still busy inside window", {31'b0, ctl_rdata[31]}, 32'h1);
        wait_idle(300);
        check("R11 timeout status", {29'b0, ctl_rdata[30:28]}, 32'h4);
        check("R11 valid dropped", {31'b0, req_valid}, 32'h0);
        check("R11 no handshake", hs_cnt - h0, 0);
        rsp_on = 1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg_read();
        t_status_and_reset();
        t_lock();
        t_ids();
        t_misalign();
        t_clear();
        t_busy_ignore();
        t_rsp_error();
        t_hold();
        t_timeout();
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

endmodule